// File: doc/BRIEF.md
# Clock-Ready Startup Delay Controller

This block measures the warm-up time of the crystal oscillator and its clock multiplier before the multiplied clock may drive the system. A delay counter runs whenever the multiplier enable goes high, or whenever the oscillator restarts on leaving Stop mode while the multiplier is enabled. When the count finishes, the block raises a ready flag. Until then, it refuses any request that would pick the multiplied clock as the system source. Requests for the divided crystal clocks go through at once.

The block also holds a ring-mode status flag. The flag shows whether the device runs from its internal ring oscillator. It clears only on power-on reset and keeps its value through every other reset. The block contains no clock-switching circuits. It only produces the selector code and the two status flags. Divider codes (2 bits): 00 picks the multiplied clock, 01 divide-by-1, 10 divide-by-4, 11 divide-by-1024.

Top module: `clkrdy_ctrl`

## Requirements
- R1: While any reset is asserted (`rst_n` or `por_n` low), at the next clock edge `ready` is 0, the counter is idle and `sel_cur` equals the reset code 10 (divide-by-4).
- R2: When `mult_en` changes from 0 to 1, `ready` becomes 1 exactly DELAY clock edges after the edge that first samples `mult_en` high.
- R3: While the delay count is running, `ready` stays 0.
- R4: When `mult_en` is sampled low, the next edge clears `ready` and stops the count. `ready` stays 0 for as long as `mult_en` stays low.
- R5: A `stop_exit` pulse sampled while `mult_en` is high clears `ready` at that edge and restarts the count. `ready` returns DELAY edges after that edge.
- R6: A `stop_exit` pulse sampled while `mult_en` is low does nothing: `ready` stays 0. A later rise of `mult_en` still gives the full DELAY.
- R7: A write (`sel_wr` high) of any code other than 00 loads `sel_cur` at the next edge, whatever the state of `ready`.
- R8: A write of code 00 while `ready` is 0 is dropped. `sel_cur` keeps its value, and the code is not applied later when `ready` rises.
- R9: A write of code 00 while `ready` is 1 loads `sel_cur` at the next edge.
- R10: Outside reset, `ring_mode` equals the value `ring_active` had at the previous clock edge.
- R11: `ring_mode` holds its value while only `rst_n` is low. It is cleared to 0 by `por_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low general reset (all non-power-on resets) |
| por_n | input | 1 | Synchronous active-low power-on reset |
| mult_en | input | 1 | Clock multiplier enable control |
| stop_exit | input | 1 | One-cycle pulse: oscillator restarted on leaving Stop mode |
| sel_wr | input | 1 | Write strobe for the divider select |
| sel_wdata | input | 2 | Requested divider code |
| ring_active | input | 1 | High while the ring oscillator is the clock source |
| ready | output | 1 | Clock-ready flag |
| ring_mode | output | 1 | Ring-mode status flag |
| sel_cur | output | 2 | Divider code currently in force |

## Verification
Every result is registered once, so a change on an input shows up on the outputs just after the edge that samples it. The exception is `ready`: it rises DELAY edges after the sampling edge of a `mult_en` rise or a `stop_exit`. The bench changes inputs and reads outputs 1 ns after a rising edge. It counts the edges it lets pass. It reads `ready` one edge before the due time, expecting 0, and again at the due time, expecting 1. Select writes and ring-mode changes are checked one edge after they are driven.

// File: rtl/clkrdy_pkg.sv
package clkrdy_pkg;
    typedef logic [1:0] clksel_t;
    localparam clksel_t CLKSEL_MULT  = 2'b00;
    localparam clksel_t CLKSEL_DIV1  = 2'b01;
    localparam clksel_t CLKSEL_DIV4  = 2'b10;
    localparam clksel_t CLKSEL_DIV1K = 2'b11;
endpackage

// File: rtl/clkrdy_timer.sv
module clkrdy_timer #(
    parameter int unsigned DELAY = 65536
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mult_en_i,
    input  logic stop_exit_i,
    output logic ready_o
);
    localparam int CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             rdy;
        logic             prev;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = mult_en_i;
        if (!mult_en_i) begin
            st_d.run = 1'b0;
            st_d.rdy = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.prev || stop_exit_i) begin
            st_d.run = 1'b1;
            st_d.rdy = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            if (st_q.cnt == LAST) begin
                st_d.run = 1'b0;
                st_d.rdy = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign ready_o = st_q.rdy;

    // R4: enable low forces ready low at the next edge
    assert_en_low_clears_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !mult_en_i |=> !ready_o);
    // R5: restart trigger while enabled clears ready
    assert_restart_clears_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (mult_en_i && (stop_exit_i || !st_q.prev)) |=> (!ready_o && st_q.run));
    // R2: ready only rises when the count reached its last value
    assert_ready_at_end_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ready_o) |-> ($past(st_q.cnt) == LAST && $past(st_q.run)));
    // R3: never ready while counting
    assert_not_ready_running_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.run |-> !ready_o);
endmodule

// File: rtl/clksel_gate.sv
module clksel_gate
    import clkrdy_pkg::*;
#(
    parameter clksel_t SEL_RST = CLKSEL_DIV4
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    ready_i,
    input  logic    wr_i,
    input  clksel_t wdata_i,
    output clksel_t sel_o
);
    typedef struct packed {
        clksel_t sel;
    } gate_t;

    gate_t st_d, st_q;
    logic  locked;

    always_comb begin
        st_d   = st_q;
        locked = (wdata_i == CLKSEL_MULT) && !ready_i;
        if (wr_i && !locked) st_d.sel = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q.sel <= SEL_RST;
        else       st_q     <= st_d;
    end

    assign sel_o = st_q.sel;

    // R8: multiplied-clock request before ready leaves selection untouched
    assert_lockout_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && wdata_i == CLKSEL_MULT && !ready_i) |=> $stable(sel_o));
    // R7: other codes always load
    assert_plain_load_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && wdata_i != CLKSEL_MULT) |=> (sel_o == $past(wdata_i)));
    // R9: multiplied clock accepted once ready
    assert_mult_load_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && wdata_i == CLKSEL_MULT && ready_i) |=> (sel_o == CLKSEL_MULT));
endmodule

// File: rtl/ringmode_hold.sv
module ringmode_hold (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic rst_n_i,
    input  logic ring_active_i,
    output logic ring_mode_o
);
    typedef struct packed {
        logic ring;
    } ring_t;

    ring_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_n_i) st_d.ring = ring_active_i;
    end

    always_ff @(posedge clk_i) begin
        if (!por_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign ring_mode_o = st_q.ring;

    // R11: non-power-on reset keeps the flag
    assert_hold_in_reset_R11: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !rst_n_i |=> $stable(ring_mode_o));
    // R10: outside reset the flag tracks the source one edge later
    assert_track_R10: assert property (@(posedge clk_i) disable iff (!por_n_i)
        rst_n_i |=> (ring_mode_o == $past(ring_active_i)));
endmodule

// File: rtl/clkrdy_ctrl.sv
module clkrdy_ctrl
    import clkrdy_pkg::*;
#(
    parameter int unsigned DELAY   = 65536,
    parameter clksel_t     SEL_RST = CLKSEL_DIV4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_n,
    input  logic       mult_en,
    input  logic       stop_exit,
    input  logic       sel_wr,
    input  logic [1:0] sel_wdata,
    input  logic       ring_active,
    output logic       ready,
    output logic       ring_mode,
    output logic [1:0] sel_cur
);
    logic rst_any;
    assign rst_any = !rst_n || !por_n;

    clkrdy_timer #(.DELAY(DELAY)) u_timer (
        .clk_i       (clk),
        .rst_i       (rst_any),
        .mult_en_i   (mult_en),
        .stop_exit_i (stop_exit),
        .ready_o     (ready)
    );

    clksel_gate #(.SEL_RST(SEL_RST)) u_gate (
        .clk_i   (clk),
        .rst_i   (rst_any),
        .ready_i (ready),
        .wr_i    (sel_wr),
        .wdata_i (sel_wdata),
        .sel_o   (sel_cur)
    );

    ringmode_hold u_ring (
        .clk_i         (clk),
        .por_n_i       (por_n),
        .rst_n_i       (rst_n),
        .ring_active_i (ring_active),
        .ring_mode_o   (ring_mode)
    );

    // R1: a reset leaves the block not ready with the reset divider code
    assert_reset_state_R1: assert property (@(posedge clk)
        rst_any |=> (!ready && sel_cur == SEL_RST));
endmodule

// File: tb/clkrdy_ctrl_tb.sv
`timescale 1ns/1ps
module clkrdy_ctrl_tb;
    localparam int DLY = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, por_n = 1'b0;
    logic       mult_en = 1'b0, stop_exit = 1'b0, sel_wr = 1'b0, ring_active = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic       ready, ring_mode;
    logic [1:0] sel_cur;
    int         errors = 0, checks = 0;

    always #2 clk = ~clk;

    clkrdy_ctrl #(.DELAY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .mult_en(mult_en),
        .stop_exit(stop_exit), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .ring_active(ring_active), .ready(ready), .ring_mode(ring_mode),
        .sel_cur(sel_cur)
    );

    // {want_ready, write code, expected sel_cur}
    localparam logic [4:0] VEC [8] = '{
        {1'b0, 2'b00, 2'b10},
        {1'b0, 2'b01, 2'b01},
        {1'b0, 2'b00, 2'b01},
        {1'b1, 2'b00, 2'b00},
        {1'b1, 2'b11, 2'b11},
        {1'b0, 2'b10, 2'b10},
        {1'b0, 2'b00, 2'b10},
        {1'b1, 2'b00, 2'b00}
    };

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic make_ready();
        mult_en = 1'b0; tick();
        mult_en = 1'b1; tick(DLY + 1);
    endtask

    task automatic wr_sel(input logic [1:0] code);
        sel_wr = 1'b1; sel_wdata = code; tick();
        sel_wr = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(2);
        chk("R1 ready in reset", ready, 0);
        chk("R1 sel in reset", sel_cur, 2'b10);
        chk("R11 ring after por", ring_mode, 0);
        por_n = 1'b1; rst_n = 1'b1; tick();

        // table walk: gating of the select under both ready states
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][4] && !ready) make_ready();
            if (!VEC[i][4]) begin mult_en = 1'b0; tick(); end
            chk("R7/R8/R9 ready state", ready, VEC[i][4]);
            wr_sel(VEC[i][3:2]);
            chk(VEC[i][3:2] == 2'b00 ? (VEC[i][4] ? "R9 mult accepted" : "R8 mult locked")
                                     : "R7 plain load", sel_cur, VEC[i][1:0]);
        end

        // R2/R3 exact ready timing
        mult_en = 1'b0; tick();
        mult_en = 1'b1; tick();
        tick(DLY / 2);
        chk("R3 not ready while counting", ready, 0);
        tick(DLY / 2 - 1);
        chk("R2 ready one edge early", ready, 0);
        tick();
        chk("R2 ready at due edge", ready, 1);

        // R4 enable low
        mult_en = 1'b0; tick();
        chk("R4 cleared on enable low", ready, 0);
        tick(DLY + 2);
        chk("R4 stays low", ready, 0);

        // R6 stop exit while disabled
        stop_exit = 1'b1; tick(); stop_exit = 1'b0; tick(DLY + 2);
        chk("R6 stop exit disabled", ready, 0);
        mult_en = 1'b1; tick(DLY);
        chk("R6 full delay one early", ready, 0);
        tick();
        chk("R6 full delay done", ready, 1);

        // R5 stop exit while enabled
        stop_exit = 1'b1; tick(); stop_exit = 1'b0;
        chk("R5 cleared by stop exit", ready, 0);
        tick(DLY - 1);
        chk("R5 one edge early", ready, 0);
        tick();
        chk("R5 ready again", ready, 1);

        // R8 locked request never applied later
        mult_en = 1'b0; tick();
        wr_sel(2'b01);
        wr_sel(2'b00);
        mult_en = 1'b1; tick(DLY + 3);
        chk("R8 ready reached", ready, 1);
        chk("R8 not queued", sel_cur, 2'b01);

        // R10/R11 ring-mode flag
        ring_active = 1'b1; tick();
        chk("R10 tracks high", ring_mode, 1);
        ring_active = 1'b0; rst_n = 1'b0; tick(3);
        chk("R11 held in reset", ring_mode, 1);
        chk("R1 ready in general reset", ready, 0);
        chk("R1 sel in general reset", sel_cur, 2'b10);
        rst_n = 1'b1; tick();
        chk("R10 tracks low", ring_mode, 0);
        ring_active = 1'b1; tick();
        chk("R10 tracks high again", ring_mode, 1);
        por_n = 1'b0; tick();
        chk("R11 cleared by por", ring_mode, 0);
        por_n = 1'b1; tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule